// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Receiver

This block listens to the two open-collector lines of a PS/2 pointing device, a serial clock and a data line that are both driven by the device, and turns the traffic into decoded movement reports. Both lines are first brought into the system clock domain. Each bit is then captured on a falling edge of the serial clock. Eleven-bit frames are checked for start, stop and odd-parity correctness. The good bytes are grouped into three-byte reports: a status byte, then the X movement byte, then the Y movement byte.

A completed report is published on the outputs: the left and right button states, the X and Y overflow flags, and the two movement deltas widened to 9-bit two's complement. A single-cycle strobe marks each new report. A rejected frame raises a single-cycle error pulse and drops any partial report. A status byte whose marker bit is clear is skipped so that the block can regain alignment. An idle timer clears a frame or report that stalls halfway. The system clock must run at 1 MHz or faster.

Top module: `ps2m_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first report, all report outputs (buttons, overflow flags, dx, dy) are 0 and pkt_valid and frame_error are 0.
- R2: A frame is 11 bits, each captured on a falling edge of the serial clock: bit 0 is the start bit (must be 0), bits 1 to 8 are the data byte with the LSB first, bit 9 is the parity bit and bit 10 is the stop bit (must be 1).
- R3: A frame whose data and parity bits together hold an even number of ones is rejected. The partial report is discarded and the next good byte is treated as a status byte.
- R4: A frame with a start bit of 1 or a stop bit of 0 is rejected in the same way as in R3.
- R5: A good byte offered as a status byte with bit 3 equal to 0 is dropped without an error. The next good byte is then treated as the status byte.
- R6: The bytes of a report are taken in the order status, X, Y. pkt_valid is high for exactly one cycle, visible after the fourth rising system clock edge that follows the serial clock's 11th falling edge of the Y frame being applied at the input.
- R7: Status bit 0 drives btn_left, bit 1 drives btn_right, bit 6 drives x_ovf and bit 7 drives y_ovf. dx = {status bit 4, X byte} and dy = {status bit 5, Y byte}.
- R8: Report outputs change only in the cycle in which pkt_valid is high, and hold their values otherwise.
- R9: If no falling serial clock edge arrives for TIMEOUT_US microseconds while a frame or a report is in progress, the bit and byte positions are cleared. A complete report sent afterwards is decoded correctly.
- R10: frame_error is high for exactly one cycle for each rejected frame, visible after the third rising system clock edge that follows the frame's 11th falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Serial clock from the device, idles high |
| ps2_dat_i | input | 1 | Serial data from the device |
| btn_left | output | 1 | Left button pressed in the last report |
| btn_right | output | 1 | Right button pressed in the last report |
| x_ovf | output | 1 | X movement overflow flag |
| y_ovf | output | 1 | Y movement overflow flag |
| dx | output | 9 | Signed X movement, right is positive |
| dy | output | 9 | Signed Y movement, up is positive |
| pkt_valid | output | 1 | One-cycle strobe for a new report |
| frame_error | output | 1 | One-cycle strobe for a rejected frame |

## Verification
The checker watches several properties on every cycle. Both strobes last one cycle, a report strobe follows a delivered byte, and a frame error follows a detected serial clock edge. The report outputs stay frozen between strobes, and an expired idle timer leaves the bit position at zero. Only the bench's scenarios can show the decoded content. These scenarios cover LSB-first assembly, field mapping and sign widening for negative and overflowing moves, the skipping of unmarked status bytes, and recovery after parity, start and stop faults and after stalls. They also pin the exact cycle of each strobe.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BYTE_W     = 8;
  localparam int DELTA_W    = BYTE_W + 1;

  // status byte field positions (decoded by the report assembler)
  localparam int ST_LEFT  = 0;
  localparam int ST_RIGHT = 1;
  localparam int ST_MARK  = 3;
  localparam int ST_XSIGN = 4;
  localparam int ST_YSIGN = 5;
  localparam int ST_XOVF  = 6;
  localparam int ST_YOVF  = 7;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_XMOVE  = 2'd1,
    SLOT_YMOVE  = 2'd2
  } slot_e;

  typedef struct packed {
    logic               left;
    logic               right;
    logic               xovf;
    logic               yovf;
    logic [DELTA_W-1:0] dx;
    logic [DELTA_W-1:0] dy;
  } report_t;

  // data bits plus parity bit must hold an odd count of ones
  function automatic logic parity_good(input logic [BYTE_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  // frame image, bit 0 = first bit received
  function automatic logic frame_good(input logic [FRAME_BITS-1:0] f);
    return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) &&
           parity_good(f[BYTE_W:1], f[BYTE_W+1]);
  endfunction

  function automatic logic [DELTA_W-1:0] widen_delta(input logic sgn,
                                                     input logic [BYTE_W-1:0] mag);
    return {sgn, mag};
  endfunction
endpackage

// File: rtl/ps2m_sync.sv
module ps2m_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic line_dat,
  output logic clk_fall,
  output logic dat_bit
);
  logic [STAGES-1:0] clk_ff;
  logic [STAGES-1:0] dat_ff;
  logic              clk_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_ff[0] <= 1'b1;
            dat_ff[0] <= 1'b1;
          end else begin
            clk_ff[0] <= line_clk;
            dat_ff[0] <= line_dat;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_ff[g] <= 1'b1;
            dat_ff[g] <= 1'b1;
          end else begin
            clk_ff[g] <= clk_ff[g-1];
            dat_ff[g] <= dat_ff[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= clk_ff[STAGES-1];
  end

  assign clk_fall = clk_prev & ~clk_ff[STAGES-1];
  assign dat_bit  = dat_ff[STAGES-1];
endmodule

// File: rtl/ps2m_frame.sv
module ps2m_frame
  import ps2m_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_fall,
  input  logic              dat_bit,
  input  logic              flush,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              frame_bad,
  output logic [3:0]        bit_pos,
  output logic              in_frame
);
  localparam int LAST_BIT = FRAME_BITS - 1;

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_img;

  assign frame_img = {dat_bit, shreg[FRAME_BITS-1:1]};
  assign in_frame  = (bit_pos != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos   <= 4'd0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_q    <= '0;
      frame_bad <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_bad <= 1'b0;
      if (flush) begin
        bit_pos <= 4'd0;
      end else if (clk_fall) begin
        shreg <= frame_img;
        if (bit_pos == 4'(LAST_BIT)) begin
          bit_pos <= 4'd0;
          if (frame_good(frame_img)) begin
            byte_vld <= 1'b1;
            byte_q   <= frame_img[BYTE_W:1];
          end else begin
            frame_bad <= 1'b1;
          end
        end else begin
          bit_pos <= bit_pos + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2m_idle_timer.sv
module ps2m_idle_timer #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic clk_fall,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt;

  assign expire = busy && !clk_fall && (cnt == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!busy || clk_fall)   cnt <= '0;
    else if (expire)              cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ps2m_packet.sv
module ps2m_packet
  import ps2m_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic              frame_bad,
  input  logic              flush,
  output report_t           rpt,
  output logic              pkt_valid,
  output slot_e             slot,
  output logic              mark_drop
);
  logic              h_left, h_right, h_xs, h_ys, h_xo, h_yo;
  logic [BYTE_W-1:0] h_x;

  assign mark_drop = byte_vld && (slot == SLOT_STATUS) && !byte_q[ST_MARK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= SLOT_STATUS;
      rpt       <= '0;
      pkt_valid <= 1'b0;
      h_left    <= 1'b0;
      h_right   <= 1'b0;
      h_xs      <= 1'b0;
      h_ys      <= 1'b0;
      h_xo      <= 1'b0;
      h_yo      <= 1'b0;
      h_x       <= '0;
    end else begin
      pkt_valid <= 1'b0;
      if (flush || frame_bad) begin
        slot <= SLOT_STATUS;
      end else if (byte_vld) begin
        unique case (slot)
          SLOT_STATUS: begin
            if (!mark_drop) begin
              h_left  <= byte_q[ST_LEFT];
              h_right <= byte_q[ST_RIGHT];
              h_xs    <= byte_q[ST_XSIGN];
              h_ys    <= byte_q[ST_YSIGN];
              h_xo    <= byte_q[ST_XOVF];
              h_yo    <= byte_q[ST_YOVF];
              slot    <= SLOT_XMOVE;
            end
          end
          SLOT_XMOVE: begin
            h_x  <= byte_q;
            slot <= SLOT_YMOVE;
          end
          default: begin
            rpt.left  <= h_left;
            rpt.right <= h_right;
            rpt.xovf  <= h_xo;
            rpt.yovf  <= h_yo;
            rpt.dx    <= widen_delta(h_xs, h_x);
            rpt.dy    <= widen_delta(h_ys, byte_q);
            pkt_valid <= 1'b1;
            slot      <= SLOT_STATUS;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2m_rx.sv
module ps2m_rx
  import ps2m_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int TIMEOUT_US  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ps2_clk_i,
  input  logic               ps2_dat_i,
  output logic               btn_left,
  output logic               btn_right,
  output logic               x_ovf,
  output logic               y_ovf,
  output logic [DELTA_W-1:0] dx,
  output logic [DELTA_W-1:0] dy,
  output logic               pkt_valid,
  output logic               frame_error
);
  localparam int TIMEOUT_CYC = (CLK_KHZ * TIMEOUT_US) / 1000;

  logic              ps_fall, ps_bit, expire, byte_vld, frame_bad, in_frame, mark_drop;
  logic [BYTE_W-1:0] byte_q;
  logic [3:0]        bit_pos;
  slot_e             slot;
  report_t           rpt;

  ps2m_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_clk(ps2_clk_i), .line_dat(ps2_dat_i),
    .clk_fall(ps_fall), .dat_bit(ps_bit)
  );

  ps2m_frame u_frame (
    .clk(clk), .rst_n(rst_n), .clk_fall(ps_fall), .dat_bit(ps_bit), .flush(expire),
    .byte_vld(byte_vld), .byte_q(byte_q), .frame_bad(frame_bad),
    .bit_pos(bit_pos), .in_frame(in_frame)
  );

  ps2m_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(in_frame || (slot != SLOT_STATUS)),
    .clk_fall(ps_fall), .expire(expire)
  );

  ps2m_packet u_pkt (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_q(byte_q),
    .frame_bad(frame_bad), .flush(expire), .rpt(rpt), .pkt_valid(pkt_valid),
    .slot(slot), .mark_drop(mark_drop)
  );

  assign btn_left    = rpt.left;
  assign btn_right   = rpt.right;
  assign x_ovf       = rpt.xovf;
  assign y_ovf       = rpt.yovf;
  assign dx          = rpt.dx;
  assign dy          = rpt.dy;
  assign frame_error = frame_bad;
endmodule

// File: rtl/ps2m_rx_chk.sv
module ps2m_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       frame_error,
  input logic [8:0] dx,
  input logic [8:0] dy,
  input logic       byte_vld,
  input logic       mark_drop,
  input logic       ps_fall,
  input logic       expire,
  input logic [3:0] bit_pos
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R6
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(byte_vld) && !$past(mark_drop)); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error); // R10
  AST_ERR_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> $past(ps_fall)); // R10
  AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && frame_error)); // R3
  AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> $stable(dx) && $stable(dy)); // R8
  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> bit_pos == 4'd0); // R9
endmodule

bind ps2m_rx ps2m_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .frame_error(frame_error),
  .dx(dx), .dy(dy), .byte_vld(byte_vld), .mark_drop(mark_drop),
  .ps_fall(ps_fall), .expire(expire), .bit_pos(bit_pos)
);

// File: tb/ps2m_rx_tb.sv
module ps2m_rx_tb;
  localparam int TO_US  = 10;
  localparam int TO_CYC = 50 * TO_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk = 1'b1;
  logic pdat = 1'b1;
  logic btn_left, btn_right, x_ovf, y_ovf, pkt_valid, frame_error;
  logic [8:0] dx, dy;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit running = 0;
  bit done = 0;

  int          pv_q[$];
  int          fe_q[$];
  logic [21:0] rpt_q[$];
  logic [21:0] exp_rpt = '0;

  int         m_idx = 0;
  logic [7:0] m_st = '0;
  logic [7:0] m_x = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ps2m_rx #(.CLK_KHZ(50000), .TIMEOUT_US(TO_US), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
    .btn_left(btn_left), .btn_right(btn_right), .x_ovf(x_ovf), .y_ovf(y_ovf),
    .dx(dx), .dy(dy), .pkt_valid(pkt_valid), .frame_error(frame_error)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, expv);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && running) begin
      bit exp_pv, exp_fe;
      exp_pv = (pv_q.size() > 0) && (pv_q[0] == cyc);
      exp_fe = (fe_q.size() > 0) && (fe_q[0] == cyc);
      if (exp_pv) begin
        void'(pv_q.pop_front());
        exp_rpt = rpt_q.pop_front();
      end
      if (exp_fe) void'(fe_q.pop_front());
      check("R6", "pkt_valid", 32'(pkt_valid), 32'(exp_pv));
      check("R10", "frame_error", 32'(frame_error), 32'(exp_fe));
      check("R7/R8", "report", 32'({btn_left, btn_right, x_ovf, y_ovf, dx, dy}),
            32'(exp_rpt));
    end
  end

  // model of report assembly for one accepted byte whose last edge was at cycle n
  task automatic model_byte(input logic [7:0] b, input int n);
    case (m_idx)
      0: if (b[3]) begin m_st = b; m_idx = 1; end  // R5 marker
      1: begin m_x = b; m_idx = 2; end
      default: begin
        pv_q.push_back(n + 4);
        rpt_q.push_back({m_st[0], m_st[1], m_st[6], m_st[7],
                         m_st[4], m_x, m_st[5], b});
        m_idx = 0;
      end
    endcase
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par,
                            input bit bad_start, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      pdat = f[i];
      repeat (10) @(negedge clk);
      pclk = 1'b0;
      if (i == 10) begin
        if (bad_par || bad_start || bad_stop) begin
          fe_q.push_back(cyc + 3);
          m_idx = 0;
        end else begin
          model_byte(b, cyc);
        end
      end
      repeat (20) @(negedge clk);
      pclk = 1'b1;
      repeat (10) @(negedge clk);
    end
    pdat = 1'b1;
    repeat (50) @(negedge clk);
  endtask

  task automatic send_packet(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
    send_frame(s, 0, 0, 0);
    send_frame(x, 0, 0, 0);
    send_frame(y, 0, 0, 0);
  endtask

  task automatic send_partial(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      pdat = (i == 0) ? 1'b0 : 1'b1;
      repeat (10) @(negedge clk);
      pclk = 1'b0;
      repeat (20) @(negedge clk);
      pclk = 1'b1;
      repeat (10) @(negedge clk);
    end
  endtask

  task automatic idle_long();
    repeat (2 * TO_CYC) @(negedge clk);
    m_idx = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset values
    check("R1", "report in reset", 32'({btn_left, btn_right, x_ovf, y_ovf, dx, dy}), 32'd0);
    check("R1", "strobes in reset", 32'({pkt_valid, frame_error}), 32'd0);
    rst_n = 1'b1;
    running = 1;
    repeat (20) @(negedge clk);
    // R2 R6 R7: left button, small positive moves
    send_packet(8'h09, 8'h05, 8'h10);
    // R7: right button, both signs negative
    send_packet(8'h3A, 8'hF0, 8'h80);
    // R7: overflow flags with both buttons
    send_packet(8'hCB, 8'hFF, 8'h01);
    // R5: unmarked status byte skipped, then a normal report
    send_frame(8'h00, 0, 0, 0);
    send_packet(8'h18, 8'h7F, 8'h02);
    // R3: parity fault in the X byte
    send_frame(8'h09, 0, 0, 0);
    send_frame(8'h22, 1, 0, 0);
    send_packet(8'h29, 8'h33, 8'hC4);
    // R4: bad start then bad stop
    send_frame(8'h09, 0, 0, 0);
    send_frame(8'h44, 0, 1, 0);
    send_frame(8'h08, 0, 0, 0);
    send_frame(8'h55, 0, 0, 0);
    send_frame(8'h66, 0, 0, 1);
    send_packet(8'h0A, 8'h01, 8'hFE);
    // R9: stalled frame, then stalled report
    send_partial(5);
    idle_long();
    send_packet(8'h19, 8'h11, 8'h22);
    send_frame(8'h09, 0, 0, 0);
    send_frame(8'h12, 0, 0, 0);
    idle_long();
    send_packet(8'h28, 8'h9A, 8'h3C);
    repeat (20) @(negedge clk);
    check("R6", "reports outstanding", 32'(pv_q.size()), 32'd0);
    check("R10", "errors outstanding", 32'(fe_q.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule